// File: doc/BRIEF.md
# Dual-Polynomial Serial CRC Unit

This block computes a cyclic redundancy check one bit per clock with a linear feedback shift register. A select input picks one of two generators: a degree-16 polynomial, x^16 + x^15 + x^2 + 1, for long data payloads, or a degree-5 polynomial, x^5 + x^2 + 1, for short control tokens. Both generators share one datapath. Only the tap pattern, the active width and the feedback bit change with the selection.

In generate mode the sender shifts the message in, most significant bit first. The register then holds the remainder of the message times x^n, divided by the generator in XOR arithmetic, where n is the degree. The sender appends these n bits to the message, on its right, to form the codeword. No padding cycles are needed, because the incoming bit is folded into the feedback.

In check mode the receiver shifts the whole received codeword through the same register. An undamaged codeword divides evenly. A flag then reports a zero remainder after the last bit. A synchronous clear starts each new packet.

Top module: `serial_crc_unit`

## Requirements
- R1: After asynchronous reset (rst_n low), `remainder` is all zeros and `match` is 0.
- R2: When `clr` is high at a clock edge, `remainder` becomes all zeros and `match` becomes 0 after that edge, even if `en` is also high.
- R3: When `en` and `clr` are both low at a clock edge, `remainder` and `match` keep their values.
- R4: With `poly_sel` = 0, after a clear followed by the shifting of a message MSB first (one bit per cycle with `en` high), `remainder` equals the message times x^16 modulo x^16 + x^15 + x^2 + 1.
- R5: With `poly_sel` = 1, `remainder[4:0]` equals the message times x^5 modulo x^5 + x^2 + 1, and `remainder[15:5]` is zero. For example, message 10100101 yields 01110.
- R6: With `check_mode` = 1, after a full codeword (message followed by its remainder, MSB first) has been shifted in, `match` is 1 and `remainder` is zero. Codeword 1010010101110 with `poly_sel` = 1 is one such case.
- R7: With `check_mode` = 1, a codeword with any single bit flipped leaves `match` at 0 and a non-zero `remainder`.
- R8: An enabled shift with `check_mode` = 0 leaves `match` at 0 after the edge.
- R9: `match` is 1 only while `remainder` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the remainder and the flag; has priority over en |
| en | input | 1 | Shift one bit on this edge |
| bit_in | input | 1 | Serial message or codeword bit, MSB first |
| poly_sel | input | 1 | 0 selects the degree-16 generator, 1 selects the degree-5 generator |
| check_mode | input | 1 | 1 selects codeword checking, 0 selects remainder generation |
| remainder | output | 16 | Current register contents; degree-5 results occupy bits 4:0 |
| match | output | 1 | After an enabled shift in check mode, high when the remainder is zero |

## Verification
The register is exposed on `remainder` after every edge. A wrong tap, a wrong feedback bit or a wrong width mask therefore shows up at the ports on the first shift that puts a 1 in the top active bit. For a random message, that is usually within a few cycles. A fault in the flag logic shows as `match` disagreeing with a zero remainder after the last codeword bit, or as `match` rising in generate mode. Single-bit corruption of random codewords tests the error-detection claim across both generators.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;

    // Register width fits the larger generator.
    localparam int CRC_W = 16;

    // Generator degrees and tap patterns (the x^n term is implied).
    localparam int              WIDE_DEG    = 16;
    localparam logic [CRC_W-1:0] WIDE_TAPS   = 16'h8005;
    localparam int              NARROW_DEG  = 5;
    localparam logic [CRC_W-1:0] NARROW_TAPS = 16'h0005;

    typedef enum logic {
        POLY_WIDE   = 1'b0,
        POLY_NARROW = 1'b1
    } poly_e;

endpackage

// File: rtl/crc_poly_cfg.sv
module crc_poly_cfg #(
    parameter int           W           = crc_unit_pkg::CRC_W,
    parameter int           WIDE_DEG    = crc_unit_pkg::WIDE_DEG,
    parameter int           NARROW_DEG  = crc_unit_pkg::NARROW_DEG,
    parameter logic [W-1:0] WIDE_TAPS   = crc_unit_pkg::WIDE_TAPS,
    parameter logic [W-1:0] NARROW_TAPS = crc_unit_pkg::NARROW_TAPS
) (
    input  logic         poly_sel,
    output logic [W-1:0] taps,
    output logic [W-1:0] width_mask,
    output logic [W-1:0] top_onehot
);
    import crc_unit_pkg::*;

    logic [W-1:0] wide_mask;
    logic [W-1:0] narrow_mask;
    logic [W-1:0] wide_top;
    logic [W-1:0] narrow_top;

    // Per-bit masks and top-bit selectors derived from the degrees.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign wide_mask[i]   = (i < WIDE_DEG);
        assign narrow_mask[i] = (i < NARROW_DEG);
        assign wide_top[i]    = (i == WIDE_DEG - 1);
        assign narrow_top[i]  = (i == NARROW_DEG - 1);
    end

    always_comb begin
        if (poly_e'(poly_sel) == POLY_NARROW) begin
            taps       = NARROW_TAPS & narrow_mask;
            width_mask = narrow_mask;
            top_onehot = narrow_top;
        end else begin
            taps       = WIDE_TAPS & wide_mask;
            width_mask = wide_mask;
            top_onehot = wide_top;
        end
    end

endmodule

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
    parameter int W = crc_unit_pkg::CRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    input  logic [W-1:0] taps,
    input  logic [W-1:0] width_mask,
    input  logic [W-1:0] top_onehot,
    output logic [W-1:0] rem,
    output logic [W-1:0] rem_next
);
    typedef struct packed {
        logic [W-1:0] rem;
    } lfsr_state_t;

    lfsr_state_t state_d, state_q;
    logic        fb;
    logic [W-1:0] stepped;

    always_comb begin
        // The top bit of the active width, XORed with the incoming bit,
        // decides whether the generator is subtracted.
        fb      = bit_in ^ (|(state_q.rem & top_onehot));
        stepped = ((state_q.rem << 1) ^ (fb ? taps : '0)) & width_mask;
        state_d = state_q;
        if (clr) begin
            state_d.rem = '0;
        end else if (en) begin
            state_d.rem = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rem      = state_q.rem;
    assign rem_next = state_d.rem;

endmodule

// File: rtl/crc_match_flag.sv
module crc_match_flag #(
    parameter int W = crc_unit_pkg::CRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         check_mode,
    input  logic [W-1:0] rem_next,
    output logic         match
);
    typedef struct packed {
        logic match;
    } flag_state_t;

    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d.match = 1'b0;
        end else if (en) begin
            state_d.match = check_mode && (rem_next == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign match = state_q.match;

endmodule

// File: rtl/serial_crc_unit.sv
module serial_crc_unit #(
    parameter int           W           = crc_unit_pkg::CRC_W,
    parameter int           WIDE_DEG    = crc_unit_pkg::WIDE_DEG,
    parameter int           NARROW_DEG  = crc_unit_pkg::NARROW_DEG,
    parameter logic [W-1:0] WIDE_TAPS   = crc_unit_pkg::WIDE_TAPS,
    parameter logic [W-1:0] NARROW_TAPS = crc_unit_pkg::NARROW_TAPS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    input  logic         poly_sel,
    input  logic         check_mode,
    output logic [W-1:0] remainder,
    output logic         match
);
    logic [W-1:0] taps;
    logic [W-1:0] width_mask;
    logic [W-1:0] top_onehot;
    logic [W-1:0] rem_next;

    crc_poly_cfg #(
        .W          (W),
        .WIDE_DEG   (WIDE_DEG),
        .NARROW_DEG (NARROW_DEG),
        .WIDE_TAPS  (WIDE_TAPS),
        .NARROW_TAPS(NARROW_TAPS)
    ) cfg_i (
        .poly_sel  (poly_sel),
        .taps      (taps),
        .width_mask(width_mask),
        .top_onehot(top_onehot)
    );

    crc_lfsr #(.W(W)) lfsr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .en        (en),
        .bit_in    (bit_in),
        .taps      (taps),
        .width_mask(width_mask),
        .top_onehot(top_onehot),
        .rem       (remainder),
        .rem_next  (rem_next)
    );

    crc_match_flag #(.W(W)) flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .en        (en),
        .check_mode(check_mode),
        .rem_next  (rem_next),
        .match     (match)
    );

endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk #(
    parameter int W          = 16,
    parameter int NARROW_DEG = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         en,
    input logic         poly_sel,
    input logic         check_mode,
    input logic [W-1:0] remainder,
    input logic         match
);
    localparam logic [W-1:0] HI_MASK = ~((W'(1) << NARROW_DEG) - W'(1));

    // R2
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (remainder == '0) && !match);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(remainder) && $stable(match));

    // R5
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poly_sel && !clr && ((remainder & HI_MASK) == '0)) |=> ((remainder & HI_MASK) == '0));

    // R8
    gen_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !check_mode) |=> !match);

    // R9
    match_means_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (remainder == '0));

endmodule

bind serial_crc_unit crc_unit_chk #(.W(W), .NARROW_DEG(NARROW_DEG)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .en        (en),
    .poly_sel  (poly_sel),
    .check_mode(check_mode),
    .remainder (remainder),
    .match     (match)
);

// File: tb/serial_crc_unit_tb_top.sv
`timescale 1ns/1ps
module serial_crc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        en = 1'b0;
    logic        bit_in = 1'b0;
    logic        poly_sel = 1'b0;
    logic        check_mode = 1'b0;
    logic [15:0] remainder;
    logic        match;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    serial_crc_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .en        (en),
        .bit_in    (bit_in),
        .poly_sel  (poly_sel),
        .check_mode(check_mode),
        .remainder (remainder),
        .match     (match)
    );

    // Long division of msg * x^deg by the generator.
    function automatic logic [15:0] model_rem(input logic [63:0] msg, input int len, input bit narrow);
        int          deg = narrow ? 5 : 16;
        logic [16:0] g   = narrow ? 17'b0_0000_0000_0010_0101 : 17'h1_8005;
        logic [16:0] r   = '0;
        for (int i = 0; i < len + deg; i++) begin
            logic b = (i < len) ? msg[len-1-i] : 1'b0;
            r = {r[15:0], b};
            if (r[deg]) r = r ^ g;
        end
        return r[15:0];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic shift_bit(input logic b);
        en = 1'b1;
        bit_in = b;
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic send(input logic [63:0] msg, input int len);
        for (int i = len - 1; i >= 0; i--) shift_bit(msg[i]);
    endtask

    initial begin
        int   seed;
        int   deg;
        int   len;
        int   pos;
        logic [63:0] msg;
        logic [63:0] cw;
        logic [15:0] exp_rem;
        bit   narrow;

        seed = $urandom(32'h5EED);
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 remainder", remainder, 16'h0);
        chk("R1 match", {15'h0, match}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: stated narrow example
        poly_sel = 1'b1;
        check_mode = 1'b0;
        do_clear();
        send(64'b10100101, 8);
        chk("R5 example remainder", remainder, 16'b01110);
        // R8: generate mode leaves match low
        chk("R8 match in generate", {15'h0, match}, 16'h0);

        // R3: hold while idle
        repeat (3) @(negedge clk);
        chk("R3 hold remainder", remainder, 16'b01110);

        // R2: clear wins over enable
        en = 1'b1;
        bit_in = 1'b1;
        clr = 1'b1;
        @(negedge clk);
        en = 1'b0;
        clr = 1'b0;
        chk("R2 clear with en", remainder, 16'h0);

        // R6: stated codeword
        check_mode = 1'b1;
        send(64'b1010010101110, 13);
        chk("R6 example match", {15'h0, match}, 16'h1);
        chk("R6 example remainder", remainder, 16'h0);
        repeat (2) @(negedge clk);
        chk("R3 hold match", {15'h0, match}, 16'h1);
        do_clear();
        chk("R2 clear drops match", {15'h0, match}, 16'h0);

        // R4: directed wide cases
        poly_sel = 1'b0;
        check_mode = 1'b0;
        do_clear();
        send(64'hFFFF, 16);
        chk("R4 wide all ones", remainder, model_rem(64'hFFFF, 16, 1'b0));
        do_clear();
        send(64'h1, 1);
        chk("R4 wide single one", remainder, 16'h8005);

        // Random mix
        for (int it = 0; it < 60; it++) begin
            narrow = $urandom_range(0, 1);
            deg    = narrow ? 5 : 16;
            len    = $urandom_range(1, 32);
            msg    = {32'h0, $urandom()};
            if (len < 64) msg = msg & ((64'h1 << len) - 64'h1);
            exp_rem = model_rem(msg, len, narrow);
            poly_sel   = narrow;
            check_mode = 1'b0;
            do_clear();
            send(msg, len);
            if (narrow) chk("R5 random remainder", remainder, exp_rem);
            else        chk("R4 random remainder", remainder, exp_rem);
            chk("R8 random no match", {15'h0, match}, 16'h0);

            cw = (msg << deg) | {48'h0, exp_rem};
            check_mode = 1'b1;
            do_clear();
            send(cw, len + deg);
            chk("R6 random match", {15'h0, match}, 16'h1);

            pos = $urandom_range(0, len + deg - 1);
            cw[pos] = ~cw[pos];
            do_clear();
            send(cw, len + deg);
            chk("R7 corrupted match", {15'h0, match}, 16'h0);
            checks++;
            if (remainder == 16'h0) begin
                errors++;
                $display("FAIL R7 corrupted remainder: actual=%h expected=nonzero", remainder);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule